// File: doc/BRIEF.md
# Prioritized Edge Interrupt Controller

This controller watches sixteen interrupt request lines and one dedicated urgent line, all sampled on a single clock. A rising edge on a request line is an interrupt event. Every event clears that line's bit in a status word, so a pending source reads as 0. Each source has a programmable 3-bit level. The event is passed on only when that level is strictly greater than a global mask value. A passed event shows up one cycle later as a numeric code on `irq_code`, qualified by a one-cycle `irq_valid` strobe. The code is 16 plus the source index, or 32 for the urgent line. A falling edge on any line sends code 0, which tells the consumer that the interrupt has gone away.

A byte-wide register port reaches a 32-byte window. It holds the status word, the mask word and four level words, and each byte is read or written on its own. The source index follows a fixed assignment of the request lines. Indices 0–6 are external lines 1–7, 7–10 are DMA channels 3 down to 0, 11–12 are serial ports 0 and 1, and 13–15 are timers 0 to 2. Only one event is reported per cycle.

The reporting core is a three-state machine. `EV_IDLE` means no strobe. `EV_RAISE` means a strobe carrying 16+s or 32. `EV_DROP` means a strobe carrying 0. Each cycle the next state is chosen from that cycle's edges, whatever the current state is:
- urgent rise → `EV_RAISE`
- else a gated source rise → `EV_RAISE`
- else any fall → `EV_DROP`
- else → `EV_IDLE`

Top module: `prio_edge_irc`

## Requirements
- R1: After `rst_n` is released, the status word reads 0x0000FFFF, the mask word and the four level words read 0, and `irq_valid` is 0.
- R2: Word offsets are: status at 0x00, mask at 0x04, and level words at 0x10, 0x14, 0x18 and 0x1C. Byte lane b (address bits [1:0]) of a word maps to its bits [8b+7:8b]. Every byte can be written and read back on its own.
- R3: Offsets 0x08–0x0F read as 0, and writes to them change no register.
- R4: A rising edge on source s clears status bit s on that clock, whether the event is passed on or not. A byte write to the status word overwrites that byte, so writing 1s re-arms the bits.
- R5: The level of source s is bits [(s%4)*8+2:(s%4)*8] of level word s/4. The other bits of each byte are stored but ignored.
- R6: A source rise is passed on only when its level is strictly greater than the full 32-bit mask word, compared unsigned. A passed event gives `irq_valid`=1 with `irq_code`=16+s in the cycle after the edge.
- R7: A rising edge on `pri_irq` gives code 32 regardless of the mask, and it wins over any source rise in the same cycle.
- R8: When several passed source rises occur in one cycle, only the lowest-indexed one is reported.
- R9: A falling edge on any source or on `pri_irq`, in a cycle with no reported rise, gives one strobe with code 0.
- R10: A pulse on `regs_clr` restores the status, mask and level words to their R1 values.
- R11: `irq_valid` is high for exactly one cycle per reported event and is never high without a triggering edge in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regs_clr | input | 1 | Synchronous restore of the register window |
| src_irq | input | 16 | Interrupt request lines, index 0..15 |
| pri_irq | input | 1 | Dedicated urgent request line |
| bus_addr | input | 5 | Byte offset in the register window |
| bus_we | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Byte read data (combinational from `bus_addr`) |
| irq_valid | output | 1 | One-cycle strobe qualifying `irq_code` |
| irq_code | output | 6 | Reported code: 0, 16+s or 32 |

## Verification
A corrupted level field or mask word shows up at the very next edge on the affected source. Either the strobe is missing, or it appears with a code the scoreboard did not queue. A wrong status bit is visible on a byte read in the cycle after the edge. A stuck or misdirected state in the reporting machine turns into a duplicate strobe, a missing strobe or a wrong code one cycle after the triggering edge. The scoreboard catches it at that cycle, or through entries left in the queue at the end.

// File: rtl/irc_pkg.sv
package irc_pkg;
    localparam int NUM_SRC         = 16;
    localparam int LVL_W           = 3;
    localparam int WORD_W          = 32;
    localparam int BYTE_W          = 8;
    localparam int WIN_ADDR_W      = 5;
    localparam int FIELDS_PER_WORD = WORD_W / BYTE_W;
    localparam int NUM_LVL_WORDS   = NUM_SRC / FIELDS_PER_WORD;
    localparam int IDX_W           = $clog2(NUM_SRC);
    localparam int CODE_W          = 6;
    localparam int SRC_CODE_BASE   = 16;
    localparam int PRI_CODE        = 32;
    localparam int CLR_CODE        = 0;
    localparam logic [WORD_W-1:0] STATUS_RST = WORD_W'((64'd1 << NUM_SRC) - 1);

    // word index (address bits [4:2]) of the mapped registers
    localparam logic [2:0] WIDX_STATUS = 3'd0;
    localparam logic [2:0] WIDX_MASK   = 3'd1;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_RAISE,
        EV_DROP
    } ev_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_PRI,
        K_SRC,
        K_FALL
    } ev_kind_e;
endpackage

// File: rtl/irc_regbank.sv
module irc_regbank
    import irc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              regs_clr,
    input  logic [WIN_ADDR_W-1:0]             bus_addr,
    input  logic                              bus_we,
    input  logic [BYTE_W-1:0]                 bus_wdata,
    output logic [BYTE_W-1:0]                 bus_rdata,
    input  logic [NUM_SRC-1:0]                src_rise,
    output logic [WORD_W-1:0]                 mask_word,
    output logic [NUM_SRC-1:0][LVL_W-1:0]     src_lvl
);
    logic [WORD_W-1:0]                     status_q, status_wr;
    logic [WORD_W-1:0]                     mask_q;
    logic [NUM_LVL_WORDS-1:0][WORD_W-1:0]  lvl_q;
    logic [2:0]                            widx;
    logic [1:0]                            lane;
    logic [WORD_W-1:0]                     rd_word;
    logic [WORD_W-1:0]                     rise_word;

    assign widx      = bus_addr[4:2];
    assign lane      = bus_addr[1:0];
    assign rise_word = {{(WORD_W-NUM_SRC){1'b0}}, src_rise};

    // status after a possible byte write, before the event clear
    always_comb begin
        status_wr = status_q;
        if (bus_we && widx == WIDX_STATUS)
            status_wr[int'(lane)*BYTE_W +: BYTE_W] = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= STATUS_RST;
            mask_q   <= '0;
            lvl_q    <= '0;
        end else if (regs_clr) begin
            status_q <= STATUS_RST;
            mask_q   <= '0;
            lvl_q    <= '0;
        end else begin
            status_q <= status_wr & ~rise_word;
            if (bus_we && widx == WIDX_MASK)
                mask_q[int'(lane)*BYTE_W +: BYTE_W] <= bus_wdata;
            for (int k = 0; k < NUM_LVL_WORDS; k++) begin
                if (bus_we && widx[2] && int'(widx[1:0]) == k)
                    lvl_q[k][int'(lane)*BYTE_W +: BYTE_W] <= bus_wdata;
            end
        end
    end

    always_comb begin
        case (widx)
            WIDX_STATUS: rd_word = status_q;
            WIDX_MASK:   rd_word = mask_q;
            3'd4, 3'd5, 3'd6, 3'd7: rd_word = lvl_q[widx[1:0]];
            default:     rd_word = '0;
        endcase
    end
    assign bus_rdata = rd_word[int'(lane)*BYTE_W +: BYTE_W];
    assign mask_word = mask_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lvl
        localparam int WSEL = s / FIELDS_PER_WORD;
        localparam int BPOS = (s % FIELDS_PER_WORD) * BYTE_W;
        assign src_lvl[s] = lvl_q[WSEL][BPOS +: LVL_W];
    end

    assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|src_rise) && !regs_clr) |=> ((status_q & $past(rise_word)) == '0));

    assert_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        regs_clr |=> (status_q == STATUS_RST && mask_q == '0 && lvl_q == '0));
endmodule

// File: rtl/irc_level_gate.sv
module irc_level_gate
    import irc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_SRC-1:0]                src_rise,
    input  logic [NUM_SRC-1:0][LVL_W-1:0]     src_lvl,
    input  logic [WORD_W-1:0]                 mask_word,
    output logic                              pass_any,
    output logic [IDX_W-1:0]                  pass_idx
);
    logic [NUM_SRC-1:0] pass;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign pass[s] = src_rise[s] && (WORD_W'(src_lvl[s]) > mask_word);
    end

    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        pass_any = 1'b0;
        pass_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pass[i]) begin
                pass_any = 1'b1;
                pass_idx = IDX_W'(i);
            end
        end
    end

    assert_gate_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pass_any |-> src_rise[pass_idx]);

    assert_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pass_any |-> ((pass & ((NUM_SRC'(1) << pass_idx) - NUM_SRC'(1))) == '0));
endmodule

// File: rtl/irc_event_fsm.sv
module irc_event_fsm
    import irc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    src_irq,
    input  logic                  pri_irq,
    output logic [NUM_SRC-1:0]    src_rise,
    input  logic                  pass_any,
    input  logic [IDX_W-1:0]      pass_idx,
    output logic                  irq_valid,
    output logic [CODE_W-1:0]     irq_code
);
    logic [NUM_SRC-1:0] src_q;
    logic               pri_q;
    logic               pri_rise, fall_any;
    ev_kind_e           kind;
    ev_state_e          state_q, state_d;
    logic [CODE_W-1:0]  code_q, code_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            pri_q <= 1'b0;
        end else begin
            src_q <= src_irq;
            pri_q <= pri_irq;
        end
    end

    assign src_rise = src_irq & ~src_q;
    assign pri_rise = pri_irq & ~pri_q;
    assign fall_any = (|(src_q & ~src_irq)) | (pri_q & ~pri_irq);

    always_comb begin
        if (pri_rise)      kind = K_PRI;
        else if (pass_any) kind = K_SRC;
        else if (fall_any) kind = K_FALL;
        else               kind = K_NONE;
    end

    always_comb begin
        unique case (kind)
            K_PRI:  begin state_d = EV_RAISE; code_d = CODE_W'(PRI_CODE); end
            K_SRC:  begin state_d = EV_RAISE; code_d = CODE_W'(SRC_CODE_BASE) + CODE_W'(pass_idx); end
            K_FALL: begin state_d = EV_DROP;  code_d = CODE_W'(CLR_CODE); end
            K_NONE: begin state_d = EV_IDLE;  code_d = '0; end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EV_IDLE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            EV_IDLE:  begin irq_valid = 1'b0; irq_code = '0; end
            EV_RAISE: begin irq_valid = 1'b1; irq_code = code_q; end
            EV_DROP:  begin irq_valid = 1'b1; irq_code = CODE_W'(CLR_CODE); end
            default:  begin irq_valid = 1'b0; irq_code = '0; end
        endcase
    end

    assert_pri_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pri_rise |=> (irq_valid && irq_code == CODE_W'(PRI_CODE)));

    assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_code == CODE_W'(CLR_CODE) || irq_code == CODE_W'(PRI_CODE) ||
                       (irq_code >= CODE_W'(SRC_CODE_BASE) && irq_code < CODE_W'(PRI_CODE))));

    assert_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> $past(pri_rise || pass_any || fall_any));

    assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_any && !pri_rise && !pass_any) |=> (irq_valid && irq_code == '0));
endmodule

// File: rtl/prio_edge_irc.sv
module prio_edge_irc
    import irc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     regs_clr,
    input  logic [NUM_SRC-1:0]       src_irq,
    input  logic                     pri_irq,
    input  logic [WIN_ADDR_W-1:0]    bus_addr,
    input  logic                     bus_we,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    output logic                     irq_valid,
    output logic [CODE_W-1:0]        irq_code
);
    logic [NUM_SRC-1:0]            src_rise;
    logic [WORD_W-1:0]             mask_word;
    logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
    logic                          pass_any;
    logic [IDX_W-1:0]              pass_idx;

    irc_regbank u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .regs_clr  (regs_clr),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_rise  (src_rise),
        .mask_word (mask_word),
        .src_lvl   (src_lvl)
    );

    irc_level_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_rise  (src_rise),
        .src_lvl   (src_lvl),
        .mask_word (mask_word),
        .pass_any  (pass_any),
        .pass_idx  (pass_idx)
    );

    irc_event_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_irq   (src_irq),
        .pri_irq   (pri_irq),
        .src_rise  (src_rise),
        .pass_any  (pass_any),
        .pass_idx  (pass_idx),
        .irq_valid (irq_valid),
        .irq_code  (irq_code)
    );
endmodule

// File: tb/sim_prio_edge_irc.sv
module sim_prio_edge_irc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        regs_clr = 1'b0;
    logic [15:0] src_irq = '0;
    logic        pri_irq = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_valid;
    logic [5:0]  irq_code;

    int checks = 0;
    int errors = 0;
    logic [5:0] exp_code_q[$];
    string      exp_tag_q[$];

    always #2 clk = ~clk;

    prio_edge_irc u0 (
        .clk(clk), .rst_n(rst_n), .regs_clr(regs_clr), .src_irq(src_irq),
        .pri_irq(pri_irq), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_valid(irq_valid), .irq_code(irq_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    // driver: apply new line values, queue the expected strobe
    task automatic drive(input logic [15:0] s, input logic p, input bit has_exp,
                         input logic [5:0] code, input string tag);
        @(negedge clk);
        src_irq = s; pri_irq = p;
        if (has_exp) begin
            exp_code_q.push_back(code);
            exp_tag_q.push_back(tag);
        end
        repeat (2) @(negedge clk);
    endtask

    // monitor: compare strobes against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && irq_valid) begin
                if (exp_code_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R11: unexpected strobe code %0d, expected none", irq_code);
                end else begin
                    automatic logic [5:0] ec = exp_code_q.pop_front();
                    automatic string      et = exp_tag_q.pop_front();
                    check(et, irq_code, ec);
                end
            end
        end
    end

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1 valid", irq_valid, 0);
        rd_chk(5'h00, 8'hFF, "R1 status b0");
        rd_chk(5'h01, 8'hFF, "R1 status b1");
        rd_chk(5'h02, 8'h00, "R1 status b2");
        rd_chk(5'h04, 8'h00, "R1 mask");
        rd_chk(5'h1F, 8'h00, "R1 level");
        // R3 unmapped
        wr(5'h08, 8'hAB);
        rd_chk(5'h08, 8'h00, "R3 read 08");
        wr(5'h0E, 8'h5A);
        rd_chk(5'h0E, 8'h00, "R3 read 0E");
        rd_chk(5'h00, 8'hFF, "R3 status untouched");
        // R2 byte map
        wr(5'h04, 8'h02);
        rd_chk(5'h04, 8'h02, "R2 mask b0");
        wr(5'h10, 8'hFD);              // src0 level 5, upper bits set (R5)
        wr(5'h15, 8'h03);              // src5 level 3
        wr(5'h16, 8'h02);              // src6 level 2
        wr(5'h1F, 8'h07);              // src15 level 7
        rd_chk(5'h10, 8'hFD, "R2 level b0");
        rd_chk(5'h15, 8'h03, "R2 level word1 b1");
        rd_chk(5'h1F, 8'h07, "R2 level word3 b3");
        // R6 / R5 single forwarded source
        drive(16'h0001, 1'b0, 1, 6'd16, "R5 src0 code");
        rd_chk(5'h00, 8'hFE, "R4 status bit0");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 src0 fall");
        // R6 level equal to mask: not forwarded, status still cleared
        drive(16'h0040, 1'b0, 0, 6'd0, "");
        rd_chk(5'h00, 8'hBE, "R4 status bit6");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 src6 fall");
        drive(16'h8000, 1'b0, 1, 6'd31, "R6 src15 code");
        rd_chk(5'h01, 8'h7F, "R4 status bit15");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 src15 fall");
        // R8 concurrency
        drive(16'h8020, 1'b0, 1, 6'd21, "R8 src5+src15");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 pair fall");
        drive(16'h8040, 1'b0, 1, 6'd31, "R8 gated-lowest");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 pair fall2");
        // R7 urgent line
        drive(16'h0001, 1'b1, 1, 6'd32, "R7 over src0");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 urgent fall");
        wr(5'h04, 8'h07);
        drive(16'h0000, 1'b1, 1, 6'd32, "R7 mask 7");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 urgent fall2");
        // R6 full-width mask
        wr(5'h04, 8'h00);
        wr(5'h05, 8'h01);
        drive(16'h8000, 1'b0, 0, 6'd0, "");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 after wide mask");
        // R4 re-arm by write
        wr(5'h00, 8'hFF);
        wr(5'h01, 8'hFF);
        rd_chk(5'h00, 8'hFF, "R4 rearm b0");
        rd_chk(5'h01, 8'hFF, "R4 rearm b1");
        // R10 register restore
        wr(5'h00, 8'h00);
        @(negedge clk);
        regs_clr = 1'b1;
        @(negedge clk);
        regs_clr = 1'b0;
        rd_chk(5'h00, 8'hFF, "R10 status");
        rd_chk(5'h05, 8'h00, "R10 mask");
        rd_chk(5'h10, 8'h00, "R10 level");
        drive(16'h0001, 1'b0, 0, 6'd0, "");
        drive(16'h0000, 1'b0, 1, 6'd0, "R9 after restore");
        repeat (4) @(negedge clk);
        check("R11 queue drained", exp_code_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule